// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit collects the four interrupt causes of a UART (receiver line errors, received data ready, transmitter wants data, and modem line activity), applies a per-cause enable, picks the most urgent pending cause and reports it through an interrupt request line and an identification byte that software reads to find out why it was interrupted. The error detectors, the FIFOs and the modem line synchronisers are outside the unit; it sees them as event pulses, levels and sampled lines.

Line error and modem activity causes are sticky: each is held until software reads the matching status register. The receive cause is a plain level supplied by the receive path. The transmit cause is held from the moment the transmit FIFO condition becomes true. It is dropped when that condition goes away, or when software reads the identification byte while it shows the transmit cause. It does not return until the condition becomes true again. The bus side only needs a read strobe and a register select. Writes reach the unit indirectly through the transmit condition.

Top module: `uart_iid`

## Requirements
- R1: With several enabled causes pending, bits 3:1 of `iid` show only the most urgent one: line errors 011, then receive data 010, then transmit 001, then modem activity 000.
- R2: Bit 0 of `iid` is 0 and `irq` is 1 whenever at least one enabled cause is pending. Otherwise bit 0 is 1, bits 3:1 are 000 and `irq` is 0.
- R3: `irq_en` bit 0 enables line errors, bit 1 receive data, bit 2 transmit and bit 3 modem activity. A disabled cause is never shown in `iid` and never raises `irq`, but its pending state is kept and appears as soon as it is enabled.
- R4: Any nonzero `lsr_evt` at a clock edge makes the line error cause pending from the next cycle. A read with `reg_sel` = 5 clears it at that edge, unless a new event arrives in the same cycle, in which case it stays pending.
- R5: The receive data cause follows `rx_avail` in the same cycle, with no storage.
- R6: A transmit cause becomes pending in the cycle after `tx_cond` goes from 0 to 1. The value of `tx_cond` before the first edge after reset counts as 0. The cause is dropped in the cycle after any edge at which `tx_cond` is 0.
- R7: A read with `reg_sel` = 2 while `iid` shows the transmit cause (bits 3:1 = 001, bit 0 = 0) clears it. It stays cleared while `tx_cond` remains 1.
- R8: A read with `reg_sel` = 2 while `iid` shows some other cause, and reads of other registers, leave a pending transmit cause in place.
- R9: From the second edge after reset, a change on any bit of `modem_in` between consecutive edges makes the modem cause pending. A read with `reg_sel` = 6 clears it, unless a change arrives in the same cycle.
- R10: Bits 7 and 6 of `iid` both equal `fifo_mode`, and bits 5 and 4 are always 0.
- R11: During and after reset, before any event, no cause is pending: `iid` = {`fifo_mode`, `fifo_mode`, 6'b000001} and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| reg_sel | input | 3 | Register select qualifying `rd_stb` (2 identification, 5 line status, 6 modem status) |
| lsr_evt | input | 4 | Line error event pulses: overrun, parity, framing, break |
| rx_avail | input | 1 | Received data ready or receive threshold reached (level) |
| tx_cond | input | 1 | Transmit holding register empty or transmit FIFO at its threshold (level) |
| modem_in | input | 4 | Sampled CTS, DSR, RI and DCD lines |
| irq_en | input | 4 | Per-cause enables, bit order as in R3 |
| fifo_mode | input | 1 | FIFO mode active |
| irq | output | 1 | Interrupt request |
| iid | output | 8 | Identification byte |

## Verification
The assertions check the sticky-cause rules on every cycle. They cover setting from line error events and from modem changes, and clearing by the matching status read. They also cover dropping the transmit cause when its condition is false, clearing it by an identification read that shows it, the one-hot grant of the arbiter, and the silence of `irq` when every enable is off. Some behaviours need the bench's scenarios, because they depend on what comes before and after. These are the full priority order with several causes pending at once, a transmit cause that stays cleared while its condition stays high and comes back only on a new rising edge, and a set and a clear that collide in the same cycle. The long random run compares the whole identification byte against an independent model cycle by cycle.

// File: rtl/uart_iid_pkg.sv
`timescale 1ns/1ps
package uart_iid_pkg;

  localparam int NSRC   = 4;
  localparam int CODE_W = 3;
  localparam int IDX_W  = $clog2(NSRC);

  // Cause index; a lower index is more urgent.
  typedef enum logic [IDX_W-1:0] {
    SRC_LS = 2'd0,
    SRC_RX = 2'd1,
    SRC_TX = 2'd2,
    SRC_MS = 2'd3
  } src_e;

  // Identification code: the most urgent cause gets the largest value.
  function automatic logic [CODE_W-1:0] code_of(input src_e s);
    return CODE_W'(NSRC - 1 - int'(s));
  endfunction

endpackage

// File: rtl/uart_iid_pend.sv
`timescale 1ns/1ps
module uart_iid_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_d;

  // A new event outranks a clear arriving in the same cycle.
  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end

  // R4, R9: set dominates clear
  a_r4_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);

  // R4, R9: a clear without a set empties the flag
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);

endmodule

// File: rtl/uart_iid_chg.sv
`timescale 1ns/1ps
module uart_iid_chg #(
  parameter int W         = 4,
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         evt_o
);

  logic [W-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  generate
    if (RISE_ONLY) begin : g_rise
      // Reset value 0 makes a level already high after reset count as new.
      assign evt_o = |(din & ~din_q);
    end else begin : g_any
      logic primed_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
      end
      // The first sample after reset only loads the history.
      assign evt_o = primed_q && (din != din_q);
    end
  endgenerate

endmodule

// File: rtl/uart_iid_prio.sv
`timescale 1ns/1ps
module uart_iid_prio #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N-1:0] above;

  assign above[0] = 1'b0;
  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign above[i] = above[i-1] | req[i-1];
    end
  endgenerate

  assign grant = req & ~above;
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

  // R1: at most one cause reported, and only a requesting one
  always_comb begin
    a_r1_grant_onehot: assert ($onehot0(grant));
    a_r1_grant_requested: assert ((grant & ~req) == '0);
  end

endmodule

// File: rtl/uart_iid.sv
`timescale 1ns/1ps
module uart_iid
  import uart_iid_pkg::*;
#(
  parameter int               SEL_W    = 3,
  parameter logic [SEL_W-1:0] ADDR_IIR = 3'd2,
  parameter logic [SEL_W-1:0] ADDR_LSR = 3'd5,
  parameter logic [SEL_W-1:0] ADDR_MSR = 3'd6,
  parameter int               LSE_W    = 4,
  parameter int               MDM_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [LSE_W-1:0] lsr_evt,
  input  logic             rx_avail,
  input  logic             tx_cond,
  input  logic [MDM_W-1:0] modem_in,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             fifo_mode,
  output logic             irq,
  output logic [7:0]       iid
);

  logic rd_iid, rd_lsr, rd_msr;
  logic ms_evt, tx_rise;
  logic pend_ls, pend_tx, pend_ms;
  logic tx_clr;
  logic [NSRC-1:0]  pend, req, grant;
  logic [IDX_W-1:0] top_idx;
  logic             any_req;
  logic [CODE_W-1:0] code;

  assign rd_iid = rd_stb && (reg_sel == ADDR_IIR);
  assign rd_lsr = rd_stb && (reg_sel == ADDR_LSR);
  assign rd_msr = rd_stb && (reg_sel == ADDR_MSR);

  // Event detectors
  uart_iid_chg #(.W(MDM_W), .RISE_ONLY(1'b0)) u_mdm_chg (
    .clk(clk), .rst_n(rst_n), .din(modem_in), .evt_o(ms_evt)
  );

  uart_iid_chg #(.W(1), .RISE_ONLY(1'b1)) u_tx_rise (
    .clk(clk), .rst_n(rst_n), .din(tx_cond), .evt_o(tx_rise)
  );

  // Sticky causes
  uart_iid_pend u_pend_ls (
    .clk(clk), .rst_n(rst_n), .set_i(|lsr_evt), .clr_i(rd_lsr), .pend_o(pend_ls)
  );

  // Transmit clears when its condition drops, or when the identification
  // read returns it as the reported cause.
  assign tx_clr = !tx_cond || (rd_iid && grant[int'(SRC_TX)]);

  uart_iid_pend u_pend_tx (
    .clk(clk), .rst_n(rst_n), .set_i(tx_rise), .clr_i(tx_clr), .pend_o(pend_tx)
  );

  uart_iid_pend u_pend_ms (
    .clk(clk), .rst_n(rst_n), .set_i(ms_evt), .clr_i(rd_msr), .pend_o(pend_ms)
  );

  // Gating and arbitration
  always_comb begin
    pend                  = '0;
    pend[int'(SRC_LS)]    = pend_ls;
    pend[int'(SRC_RX)]    = rx_avail;
    pend[int'(SRC_TX)]    = pend_tx;
    pend[int'(SRC_MS)]    = pend_ms;
  end

  assign req = pend & irq_en;

  uart_iid_prio #(.N(NSRC)) u_prio (
    .req(req), .grant(grant), .idx(top_idx), .any(any_req)
  );

  assign code = any_req ? code_of(src_e'(top_idx)) : '0;
  assign irq  = any_req;
  assign iid  = {fifo_mode, fifo_mode, 2'b00, code, ~any_req};

  // R4: line error event shows up as pending on the next cycle
  a_r4_ls_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_evt != '0) |=> pend_ls);

  // R4: line status read alone empties the line error cause
  a_r4_ls_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && lsr_evt == '0) |=> !pend_ls);

  // R9: modem status read alone empties the modem cause
  a_r9_ms_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !ms_evt) |=> !pend_ms);

  // R6: a low transmit condition leaves no transmit cause
  a_r6_tx_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_cond |=> !pend_tx);

  // R7: reading the byte while it names transmit clears that cause
  a_r7_tx_iid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iid && !iid[0] && iid[3:1] == 3'b001) |=> !pend_tx);

  // R3: nothing enabled means no request
  a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

endmodule

// File: tb/uart_iid_test.sv
`timescale 1ns/1ps
module uart_iid_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_stb;
  logic [2:0] reg_sel;
  logic [3:0] lsr_evt;
  logic       rx_avail;
  logic       tx_cond;
  logic [3:0] modem_in;
  logic [3:0] irq_en;
  logic       fifo_mode;
  logic       irq;
  logic [7:0] iid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Independent model state
  logic       m_ls, m_tx, m_ms, m_txq, m_primed;
  logic [3:0] m_mq;

  always #2.5 clk = ~clk;

  uart_iid uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .reg_sel(reg_sel),
    .lsr_evt(lsr_evt), .rx_avail(rx_avail), .tx_cond(tx_cond),
    .modem_in(modem_in), .irq_en(irq_en), .fifo_mode(fifo_mode),
    .irq(irq), .iid(iid)
  );

  function automatic logic [7:0] exp_iid();
    logic [3:0] r;
    logic [2:0] c;
    r = {m_ms, m_tx, rx_avail, m_ls} & irq_en;
    if (r[0])      c = 3'b011;
    else if (r[1]) c = 3'b010;
    else if (r[2]) c = 3'b001;
    else           c = 3'b000;
    return {fifo_mode, fifo_mode, 2'b00, c, ~|r};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_model();
    logic [7:0] e;
    e = exp_iid();
    chk("R10 upper bits", {4'h0, iid[7:4]}, {4'h0, e[7:4]});
    chk("R1 code",        {5'h0, iid[3:1]}, {5'h0, e[3:1]});
    chk("R2 bit0",        {7'h0, iid[0]},   {7'h0, e[0]});
    chk("R2 irq",         {7'h0, irq},      {7'h0, ~e[0]});
  endtask

  task automatic step();
    logic [7:0] cur;
    logic n_ls, n_tx, n_ms;
    cur  = exp_iid();
    n_ls = (|lsr_evt) | (m_ls & ~(rd_stb && reg_sel == 3'd5));
    n_ms = (m_primed && modem_in != m_mq) | (m_ms & ~(rd_stb && reg_sel == 3'd6));
    n_tx = (tx_cond & ~m_txq) |
           (m_tx & tx_cond & ~(rd_stb && reg_sel == 3'd2 && !cur[0] && cur[3:1] == 3'b001));
    @(posedge clk);
    #1;
    m_ls = n_ls; m_tx = n_tx; m_ms = n_ms;
    m_txq = tx_cond; m_mq = modem_in; m_primed = 1'b1;
  endtask

  task automatic rd(input logic [2:0] sel);
    rd_stb = 1'b1; reg_sel = sel;
    step();
    rd_stb = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rd_stb = 1'b0; reg_sel = '0; lsr_evt = '0; rx_avail = 1'b0;
    tx_cond = 1'b0; modem_in = '0; irq_en = '0; fifo_mode = 1'b0;
    m_ls = 0; m_tx = 0; m_ms = 0; m_txq = 0; m_primed = 0; m_mq = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset iid", iid, 8'h01);
    chk("R11 reset irq", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R11 idle after reset", iid, 8'h01);

    fifo_mode = 1'b1; #1;
    chk("R10 fifo bits", iid, 8'hC1);
    irq_en = 4'hF;
    step();
    chk("R11 nothing pending", iid, 8'hC1);

    // Line error, then receive underneath it
    lsr_evt = 4'b0100; step(); lsr_evt = '0;
    chk("R4 line error shown", iid, 8'hC6);
    chk("R2 irq on line error", {7'h0, irq}, 8'h01);
    rx_avail = 1'b1; #1;
    chk("R1 line error above receive", iid, 8'hC6);
    rd(3'd5);
    chk("R4 cleared by status read, R1 receive next", iid, 8'hC4);
    rx_avail = 1'b0; #1;
    chk("R5 receive follows level", iid, 8'hC1);

    // Transmit lifecycle
    tx_cond = 1'b1; step();
    chk("R6 transmit on rise", iid, 8'hC2);
    rd(3'd6);
    chk("R8 other read keeps transmit", iid, 8'hC2);
    rd(3'd2);
    chk("R7 identification read clears transmit", iid, 8'hC1);
    repeat (3) step();
    chk("R7 stays cleared while condition high", iid, 8'hC1);
    tx_cond = 1'b0; step(); tx_cond = 1'b1; step();
    chk("R6 new rise re-arms", iid, 8'hC2);
    rx_avail = 1'b1; #1;
    rd(3'd2);
    rx_avail = 1'b0; #1;
    chk("R8 read showing receive keeps transmit", iid, 8'hC2);
    tx_cond = 1'b0; step();
    chk("R6 condition low drops transmit", iid, 8'hC1);

    // Modem activity
    modem_in = 4'b0010; step();
    chk("R9 modem change shown", iid, 8'hC0);
    chk("R2 irq on modem", {7'h0, irq}, 8'h01);
    rd(3'd2);
    chk("R8 identification read keeps modem", iid, 8'hC0);
    modem_in = 4'b0011; rd(3'd6);
    chk("R9 change wins over read", iid, 8'hC0);
    rd(3'd6);
    chk("R9 status read clears modem", iid, 8'hC1);

    // Enables
    irq_en = 4'h0;
    lsr_evt = 4'b0001; step(); lsr_evt = '0;
    chk("R3 masked line error hidden", iid, 8'hC1);
    chk("R3 masked irq low", {7'h0, irq}, 8'h00);
    irq_en = 4'b0001; #1;
    chk("R3 kept pending appears on enable", iid, 8'hC6);
    lsr_evt = 4'b1000; rd(3'd5); lsr_evt = '0;
    chk("R4 event wins over read", iid, 8'hC6);
    rd(3'd5);
    irq_en = 4'hF; #1;
    chk("R4 cleared", iid, 8'hC1);
    fifo_mode = 1'b0; #1;
    chk("R10 non-fifo bits", iid, 8'h01);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      rd_stb  = ($urandom % 2) == 0;
      reg_sel = 3'($urandom % 8);
      lsr_evt = (($urandom % 8) == 0) ? 4'($urandom % 15 + 1) : 4'h0;
      if (($urandom % 6) == 0) rx_avail = ~rx_avail;
      if (($urandom % 5) == 0) tx_cond = ~tx_cond;
      if (($urandom % 8) == 0) modem_in = modem_in ^ (4'b0001 << ($urandom % 4));
      if (($urandom % 20) == 0) irq_en = 4'($urandom % 16);
      if (($urandom % 50) == 0) fifo_mode = ~fifo_mode;
      #1;
      chk_model();
      step();
      chk_model();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule